// File: doc/BRIEF.md
# Multi-drop UART receiver with standby wakeup

This block is the receive side of an asynchronous serial port meant for a shared bus on which many stations listen to the same line. It takes a serial input oversampled by a sample tick (one tick per sixteenth of a bit by default) and recovers 8-bit frames: one start bit, eight data bits with the least significant bit first, and one stop bit. Each bit is decided by a majority vote over three samples around mid-bit. The block raises a receive-full flag with the byte, a framing-error flag when the stop bit reads as zero, and an idle flag once the line has stayed high for ten bit times after a frame. One interrupt request line summarises the flags.

A station that is not addressed sets the standby bit. While the bit is set, the interrupt request is held low and received frames are discarded. A wake-method input chooses how standby ends. In address mode, a frame whose top data bit is 1 ends standby and is delivered as a normal byte. In idle mode, a quiet line of ten bit times ends standby, and the next frame is delivered. In both cases the hardware clears the standby bit by itself. The receiver runs only when both the module enable and the receiver-enable bit are set. A write to the receiver-enable bit has no effect while the module enable is low.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, rx_en, stby, rx_full, idle_flag, fe_flag and rx_irq are all 0.
- R2: With mod_en and rx_en set, a frame on rxd (a low start bit, 8 data bits LSB first, and a stop bit, each lasting 16 ticks) is decided by a majority of samples 7, 8 and 9 of each bit. It appears on rx_data, and rx_full goes to 1.
- R3: A low pulse on rxd that is high again by sample 8 of the start bit is rejected. No byte is received, and the next valid frame is received correctly.
- R4: A cfg_wr while mod_en is 0 leaves rx_en unchanged. With mod_en at 1, cfg_wr loads cfg_rx_en into rx_en.
- R5: Clearing rx_en stops reception. A frame sent while rx_en is 0 changes neither rx_data nor rx_full, and flags that were already set stay set.
- R6: cfg_wr with cfg_stby at 1 sets stby. While stby is 1, rx_irq is 0, and a frame that does not meet the wake condition leaves rx_full at 0 and rx_data unchanged.
- R7: With wake_sel at 1 (address mode), a frame received in standby whose bit 7 is 1 clears stby. That frame is loaded into rx_data and sets rx_full.
- R8: With wake_sel at 0 (idle mode), ten bit times of high line after a frame received in standby clear stby without setting idle_flag. The next frame is then received normally.
- R9: Outside standby, ten bit times (160 ticks) of high line after a frame set idle_flag. The flag is still 0 after nine bit times.
- R10: A stop bit that reads as 0 sets fe_flag. The byte is still loaded and rx_full is set.
- R11: A one-cycle pulse on rd_ack clears rx_full, idle_flag and fe_flag.
- R12: rx_irq is 1 exactly when rx_full or idle_flag is 1 and stby is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable; gates writes to rx_en and the receiver itself |
| cfg_wr | input | 1 | Control write strobe; loads cfg_rx_en and cfg_stby |
| cfg_rx_en | input | 1 | Receiver-enable value to write |
| cfg_stby | input | 1 | Standby value to write |
| wake_sel | input | 1 | Wake method: 0 = idle line, 1 = address mark |
| rd_ack | input | 1 | Clears the receive flags |
| tick | input | 1 | Oversampling tick, 16 per bit by default |
| rxd | input | 1 | Serial input, idle high |
| rx_data | output | 8 | Last delivered byte |
| rx_full | output | 1 | Byte delivered and not yet acknowledged |
| idle_flag | output | 1 | Idle line detected |
| fe_flag | output | 1 | Framing error on the delivered byte |
| stby | output | 1 | Standby bit |
| rx_en | output | 1 | Receiver-enable bit |
| rx_irq | output | 1 | Receiver interrupt request, masked in standby |

## Verification
If the standby bit is stuck or wrongly cleared, the next frame shows it at the ports. A discarded byte appears on rx_full, or a wake frame fails to appear, and stby is readable one clock after the frame's stop-bit sample. A wrong sample counter or vote shows up in rx_data on the first frame whose bit values differ near the bit edges. An idle counter with an error of one bit time is caught by sampling idle_flag and stby at nine and at eleven bit times after a frame. Random bytes with occasional bad stop bits check the data path and the framing flag frame by frame.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   function automatic logic maj3(input logic [2:0] s);
      return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
   endfunction

endpackage

// File: rtl/uart_wake_frame.sv
module uart_wake_frame
   import uart_wake_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int DBITS       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             tick,
   input  logic             rxd,
   output logic             rxd_s,
   output logic             busy,
   output logic             frame_done,
   output logic             frame_stop,
   output logic [DBITS-1:0] frame_data
);
   localparam int CW  = $clog2(OVS);
   localparam int BW  = $clog2(DBITS + 1);
   localparam int MID = OVS / 2;

   rx_state_e        state;
   logic [CW-1:0]    sc;
   logic [BW-1:0]    bc;
   logic [2:0]       v;
   logic [DBITS-1:0] sh;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rxd_s = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], rxd} >> 0;
         end
         assign rxd_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RX_IDLE;
         sc         <= '0;
         bc         <= '0;
         v          <= '0;
         sh         <= '0;
         frame_done <= 1'b0;
         frame_stop <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         if (!active) begin
            state <= RX_IDLE;
         end else if (tick) begin
            sc <= sc + 1'b1;
            if (sc == CW'(MID - 1)) v[0] <= rxd_s;
            if (sc == CW'(MID))     v[1] <= rxd_s;
            if (sc == CW'(MID + 1)) v[2] <= rxd_s;
            unique case (state)
               RX_IDLE: begin
                  sc <= CW'(1);
                  if (!rxd_s) state <= RX_START;
               end
               RX_START: begin
                  if (sc == CW'(MID) && rxd_s) begin
                     state <= RX_IDLE;
                  end else if (sc == CW'(OVS - 1)) begin
                     state <= RX_DATA;
                     bc    <= '0;
                  end
               end
               RX_DATA: begin
                  if (sc == CW'(OVS - 1)) begin
                     sh <= {maj3(v), sh[DBITS-1:1]};
                     bc <= bc + 1'b1;
                     if (bc == BW'(DBITS - 1)) state <= RX_STOP;
                  end
               end
               RX_STOP: begin
                  if (sc == CW'(MID + 1)) begin
                     frame_done <= 1'b1;
                     frame_stop <= maj3({rxd_s, v[1:0]});
                     state      <= RX_IDLE;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   assign busy       = (state != RX_IDLE);
   assign frame_data = sh;

   // R3
   start_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active && tick && state == RX_START && sc == CW'(MID) && rxd_s |=> state == RX_IDLE);

   // R2
   frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active && tick && state == RX_DATA && sc == CW'(OVS - 1) && bc == BW'(DBITS - 1)
      |=> state == RX_STOP);

endmodule

// File: rtl/uart_wake_idle.sv
module uart_wake_idle #(
   parameter int OVS       = 16,
   parameter int IDLE_BITS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic tick,
   input  logic rxd_s,
   input  logic busy,
   input  logic frame_done,
   output logic idle_pulse
);
   localparam int LIM = OVS * IDLE_BITS;
   localparam int IW  = $clog2(LIM);

   logic          armed;
   logic [IW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         cnt        <= '0;
         idle_pulse <= 1'b0;
      end else begin
         idle_pulse <= 1'b0;
         if (!active) begin
            armed <= 1'b0;
         end else if (frame_done) begin
            armed <= 1'b1;
            cnt   <= '0;
         end else if (busy) begin
            armed <= 1'b0;
         end else if (armed && tick) begin
            if (!rxd_s) begin
               cnt <= '0;
            end else if (cnt == IW'(LIM - 1)) begin
               idle_pulse <= 1'b1;
               armed      <= 1'b0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R9
   idle_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_pulse |=> !idle_pulse);

endmodule

// File: rtl/uart_wake_ctl.sv
module uart_wake_ctl #(
   parameter int DBITS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mod_en,
   input  logic             cfg_wr,
   input  logic             cfg_rx_en,
   input  logic             cfg_stby,
   input  logic             wake_sel,
   input  logic             rd_ack,
   input  logic             frame_done,
   input  logic             frame_stop,
   input  logic [DBITS-1:0] frame_data,
   input  logic             idle_pulse,
   output logic             rx_en,
   output logic             stby,
   output logic [DBITS-1:0] rx_data,
   output logic             rx_full,
   output logic             idle_flag,
   output logic             fe_flag,
   output logic             rx_irq
);
   logic wake_addr, wake_idle, accept;

   assign wake_addr = frame_done & stby & wake_sel & frame_data[DBITS-1];
   assign wake_idle = idle_pulse & stby & ~wake_sel;
   assign accept    = frame_done & (~stby | wake_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en     <= 1'b0;
         stby      <= 1'b0;
         rx_data   <= '0;
         rx_full   <= 1'b0;
         idle_flag <= 1'b0;
         fe_flag   <= 1'b0;
      end else begin
         if (cfg_wr && mod_en) rx_en <= cfg_rx_en;
         if (cfg_wr)                      stby <= cfg_stby;
         else if (wake_addr || wake_idle) stby <= 1'b0;

         if (rd_ack) begin
            rx_full   <= 1'b0;
            idle_flag <= 1'b0;
            fe_flag   <= 1'b0;
         end
         if (accept) begin
            rx_data <= frame_data;
            rx_full <= 1'b1;
            fe_flag <= ~frame_stop;
         end
         if (idle_pulse && !stby) idle_flag <= 1'b1;
      end
   end

   assign rx_irq = (rx_full | idle_flag) & ~stby;

   // R4
   ren_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr && !mod_en |=> $stable(rx_en));

   // R5
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en && !rd_ack && rx_full |=> rx_full);

   // R6
   discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done && stby && !wake_sel |=> $stable(rx_data));

   // R7
   addr_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done && stby && wake_sel && frame_data[DBITS-1] && !cfg_wr
      |=> !stby && rx_full);

   // R8
   idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle_pulse && stby && !wake_sel && !cfg_wr && !idle_flag |=> !stby && !idle_flag);

   // R10
   frame_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done && !frame_stop && !stby |=> fe_flag && rx_full);

endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
   parameter int OVS         = 16,
   parameter int DBITS       = 8,
   parameter int IDLE_BITS   = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mod_en,
   input  logic             cfg_wr,
   input  logic             cfg_rx_en,
   input  logic             cfg_stby,
   input  logic             wake_sel,
   input  logic             rd_ack,
   input  logic             tick,
   input  logic             rxd,
   output logic [DBITS-1:0] rx_data,
   output logic             rx_full,
   output logic             idle_flag,
   output logic             fe_flag,
   output logic             stby,
   output logic             rx_en,
   output logic             rx_irq
);
   generate
      if (OVS < 8 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 8");
      end
      if (DBITS < 2) begin : g_bad_dbits
         $error("DBITS must be at least 2");
      end
      if (IDLE_BITS < 1) begin : g_bad_idle
         $error("IDLE_BITS must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic             active;
   logic             rxd_s, busy, frame_done, frame_stop, idle_pulse;
   logic [DBITS-1:0] frame_data;

   assign active = mod_en & rx_en;

   uart_wake_frame #(.OVS(OVS), .DBITS(DBITS), .SYNC_STAGES(SYNC_STAGES)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .tick       (tick),
      .rxd        (rxd),
      .rxd_s      (rxd_s),
      .busy       (busy),
      .frame_done (frame_done),
      .frame_stop (frame_stop),
      .frame_data (frame_data)
   );

   uart_wake_idle #(.OVS(OVS), .IDLE_BITS(IDLE_BITS)) u_idle (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .tick       (tick),
      .rxd_s      (rxd_s),
      .busy       (busy),
      .frame_done (frame_done),
      .idle_pulse (idle_pulse)
   );

   uart_wake_ctl #(.DBITS(DBITS)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .mod_en     (mod_en),
      .cfg_wr     (cfg_wr),
      .cfg_rx_en  (cfg_rx_en),
      .cfg_stby   (cfg_stby),
      .wake_sel   (wake_sel),
      .rd_ack     (rd_ack),
      .frame_done (frame_done),
      .frame_stop (frame_stop),
      .frame_data (frame_data),
      .idle_pulse (idle_pulse),
      .rx_en      (rx_en),
      .stby       (stby),
      .rx_data    (rx_data),
      .rx_full    (rx_full),
      .idle_flag  (idle_flag),
      .fe_flag    (fe_flag),
      .rx_irq     (rx_irq)
   );

   // R12
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stby) |-> !rx_irq);

endmodule

// File: tb/uart_wake_rx_tb.sv
`timescale 1ns/1ps
module uart_wake_rx_tb;
   localparam int BIT = 32;   // clocks per bit: 16 ticks, one tick every 2 clocks

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mod_en = 1'b0, cfg_wr = 1'b0, cfg_rx_en = 1'b0, cfg_stby = 1'b0;
   logic       wake_sel = 1'b0, rd_ack = 1'b0, tick = 1'b0, rxd = 1'b1;
   logic [7:0] rx_data;
   logic       rx_full, idle_flag, fe_flag, stby, rx_en, rx_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   uart_wake_rx u_dut (
      .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .cfg_wr(cfg_wr),
      .cfg_rx_en(cfg_rx_en), .cfg_stby(cfg_stby), .wake_sel(wake_sel),
      .rd_ack(rd_ack), .tick(tick), .rxd(rxd), .rx_data(rx_data),
      .rx_full(rx_full), .idle_flag(idle_flag), .fe_flag(fe_flag),
      .stby(stby), .rx_en(rx_en), .rx_irq(rx_irq)
   );

   initial begin
      forever begin
         @(negedge clk);
         tick = ~tick;
      end
   end

   function automatic logic exp_fe(input logic stop);
      return ~stop;
   endfunction

   function automatic logic exp_irq(input logic full, input logic idl, input logic sb);
      return (full | idl) & ~sb;
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_ctl(input logic ren, input logic sb);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_rx_en = ren; cfg_stby = sb;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk);
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
   endtask

   task automatic send(input logic [7:0] b, input logic stop);
      @(negedge clk);
      rxd = 1'b0;
      wait_clk(BIT);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         wait_clk(BIT);
      end
      rxd = stop;
      if (stop) wait_clk(BIT);
      else      wait_clk(24);
      rxd = 1'b1;
      wait_clk(8);
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_up();
      end
   end

   initial begin
      logic [7:0] rb;
      logic       rs;
      int         seed;
      seed = $urandom(32'd4242);
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(2);
      // R1 reset state
      check("R1 rx_en", rx_en, 0);
      check("R1 stby", stby, 0);
      check("R1 rx_full", rx_full, 0);
      check("R1 idle_flag", idle_flag, 0);
      check("R1 fe_flag", fe_flag, 0);
      check("R1 rx_irq", rx_irq, 0);

      // R4 write ignored while module disabled
      write_ctl(1'b1, 1'b0);
      check("R4 locked", rx_en, 0);
      mod_en = 1'b1;
      write_ctl(1'b1, 1'b0);
      check("R4 write", rx_en, 1);
      wait_clk(BIT);

      // R2 basic frame, R12 irq
      send(8'hA5, 1'b1);
      check("R2 data", rx_data, 8'hA5);
      check("R2 full", rx_full, 1);
      check("R12 irq", rx_irq, exp_irq(rx_full, idle_flag, stby));
      check("R12 irq set", rx_irq, 1);
      // R11 acknowledge
      ack();
      check("R11 full clr", rx_full, 0);
      check("R12 irq clr", rx_irq, 0);

      // R3 start glitch
      @(negedge clk); rxd = 1'b0;
      wait_clk(8);
      rxd = 1'b1;
      wait_clk(BIT * 11);
      check("R3 glitch", rx_full, 0);
      send(8'h3C, 1'b1);
      check("R3 after glitch", rx_data, 8'h3C);
      ack();

      // R10 framing error
      send(8'hC3, 1'b0);
      check("R10 fe", fe_flag, exp_fe(1'b0));
      check("R10 data", rx_data, 8'hC3);
      check("R10 full", rx_full, 1);
      ack();
      check("R11 fe clr", fe_flag, 0);
      wait_clk(BIT * 2);

      // R9 idle detection
      send(8'h01, 1'b1);
      ack();
      wait_clk(280);
      check("R9 early", idle_flag, 0);
      wait_clk(60);
      check("R9 idle", idle_flag, 1);
      check("R9 irq", rx_irq, 1);
      ack();
      check("R11 idle clr", idle_flag, 0);

      // R6 standby discard, address mode
      wake_sel = 1'b1;
      write_ctl(1'b1, 1'b1);
      check("R6 stby set", stby, 1);
      send(8'h12, 1'b1);
      check("R6 discard", rx_full, 0);
      check("R6 data kept", rx_data, 8'h01);
      check("R6 still stby", stby, 1);
      check("R6 irq", rx_irq, 0);
      // R7 address wake
      send(8'h85, 1'b1);
      check("R7 stby clr", stby, 0);
      check("R7 data", rx_data, 8'h85);
      check("R7 full", rx_full, 1);
      ack();
      wait_clk(BIT * 12);
      ack();

      // R8 idle wake
      wake_sel = 1'b0;
      write_ctl(1'b1, 1'b1);
      send(8'h11, 1'b1);
      check("R8 stby hold", stby, 1);
      check("R8 discard", rx_full, 0);
      wait_clk(BIT * 12);
      check("R8 stby clr", stby, 0);
      check("R8 no idle flag", idle_flag, 0);
      send(8'h22, 1'b1);
      check("R8 next frame", rx_data, 8'h22);
      check("R8 next full", rx_full, 1);

      // R12 mask while full
      wake_sel = 1'b1;
      write_ctl(1'b1, 1'b1);
      check("R12 masked", rx_irq, 0);
      write_ctl(1'b1, 1'b0);
      check("R12 unmasked", rx_irq, 1);
      ack();
      wait_clk(BIT * 12);
      ack();

      // R5 receiver disabled keeps flags
      send(8'h5A, 1'b1);
      write_ctl(1'b0, 1'b0);
      send(8'h33, 1'b1);
      check("R5 full kept", rx_full, 1);
      check("R5 data kept", rx_data, 8'h5A);
      write_ctl(1'b1, 1'b0);
      ack();
      wait_clk(BIT);

      // R2 R10 random frames
      for (int k = 0; k < 24; k++) begin
         rb = 8'($urandom);
         rs = ($urandom % 8) != 0;
         send(rb, rs);
         check("R2 rand data", rx_data, rb);
         check("R10 rand fe", fe_flag, exp_fe(rs));
         ack();
         wait_clk(BIT * 2);
      end

      done = 1'b1;
      finish_up();
   end
endmodule